// File: doc/BRIEF.md
# Crossing Light Controller With Parade Hold

This block runs the lights at the crossing of two roads, A and B. Each road has one vehicle sensor (high while traffic waits) and one light, driven as a 2-bit colour code. A four-state Moore machine cycles the lights in a fixed order. It gives road A green for as long as A has traffic, then yellow for one clock. It then gives road B green for as long as B has traffic, then yellow for one clock, and returns to A. Each clock stands for one fixed interval of real time, and the lights move at most one state per clock.

A second, two-state machine holds a parade mode. A request pulse enters the mode and an end pulse leaves it. While the mode is on, the lights machine will not leave its road-B-green state. The lights reach that state in the usual way and then hold it until the mode ends and road B is clear. The mode bit is registered and is also brought out as an output. Both machines share one clock and one synchronous, active-high reset.

Top module: `crossing_light_ctrl`

## Requirements
- R1: A clock edge with `rst` high puts the lights in the A-green state and clears parade mode, so the outputs become `lightA`=00, `lightB`=10 and `paradeOn`=0.
- R2: The colour codes are green=00, yellow=01 and red=10. The four light states drive (lightA, lightB) as follows: A-green (00,10), A-yellow (01,10), B-green (10,00) and B-yellow (10,01).
- R3: In A-green the lights stay there on every edge where `sensA` is high, and they move to A-yellow on an edge where `sensA` is low.
- R4: A-yellow always moves to B-green on the next edge, and B-yellow always moves to A-green on the next edge, whatever the sensors show.
- R5: In B-green the lights stay there on an edge where `paradeOn` is 1 or `sensB` is high. They move to B-yellow only when both are low.
- R6: On an edge with `paradeReq` high and `paradeEnd` low, `paradeOn` becomes 1. On an edge with `paradeEnd` high and `paradeReq` low, it becomes 0. With both low it holds its value.
- R7: On an edge where `paradeReq` and `paradeEnd` are both high, `paradeOn` keeps its current value.
- R8: The B-green hold decision uses the mode value from before the edge. A request that arrives in the cycle the lights leave B-green does not stop them leaving. An end pulse that arrives while the lights are held in B-green lets them leave one edge later.
- R9: A reset edge clears both machines together, even in the middle of a parade hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sensA | input | 1 | Road A traffic present |
| sensB | input | 1 | Road B traffic present |
| paradeReq | input | 1 | Enter parade mode |
| paradeEnd | input | 1 | Leave parade mode |
| lightA | output | 2 | Road A colour code |
| lightB | output | 2 | Road B colour code |
| paradeOn | output | 1 | Current parade mode bit |

## Verification
Two events can land on the same edge: the mode machine taking a request or an end pulse, and the lights machine deciding whether to leave B-green. The bench provokes both orders. It raises `paradeReq` in the very cycle the lights leave B-green with `sensB` low, and it raises `paradeEnd` while the lights are held in B-green. The expected result uses the mode value from before the edge, so the first case leaves at once and the second leaves one edge later. It also raises both mode inputs together while the lights are held, and applies reset during a hold.

// File: rtl/xlc_pkg.sv
package xlc_pkg;
  localparam int COLOR_W = 2;
  localparam int STATE_W = 2;

  typedef logic [COLOR_W-1:0] color_t;

  localparam color_t COL_GREEN  = 2'b00;
  localparam color_t COL_YELLOW = 2'b01;
  localparam color_t COL_RED    = 2'b10;

  typedef enum logic [STATE_W-1:0] {
    ST_A_GO   = 2'b00,
    ST_A_WARN = 2'b01,
    ST_B_GO   = 2'b10,
    ST_B_WARN = 2'b11
  } light_state_t;

  // strobes from the mode control to the light datapath
  typedef struct packed {
    logic holdB;
  } ctrl_strobe_t;
endpackage

// File: rtl/xlc_mode_ctrl.sv
module xlc_mode_ctrl
  import xlc_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         paradeReq,
  input  logic         paradeEnd,
  output ctrl_strobe_t strobes
);
  logic modeQ;
  logic modeD;

  always_comb begin
    modeD = modeQ;
    if (paradeReq && !paradeEnd)      modeD = 1'b1;
    else if (paradeEnd && !paradeReq) modeD = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) modeQ <= 1'b0;
    else     modeQ <= modeD;
  end

  assign strobes.holdB = modeQ;
endmodule

// File: rtl/xlc_light_path.sv
module xlc_light_path
  import xlc_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         sensA,
  input  logic         sensB,
  input  ctrl_strobe_t strobes,
  output color_t       lightA,
  output color_t       lightB
);
  light_state_t stateQ;
  light_state_t stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_A_GO:   stateD = sensA ? ST_A_GO : ST_A_WARN;
      ST_A_WARN: stateD = ST_B_GO;
      ST_B_GO:   stateD = (strobes.holdB || sensB) ? ST_B_GO : ST_B_WARN;
      ST_B_WARN: stateD = ST_A_GO;
      default:   stateD = ST_A_GO;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_A_GO;
    else     stateQ <= stateD;
  end

  always_comb begin
    lightA = COL_RED;
    lightB = COL_RED;
    unique case (stateQ)
      ST_A_GO:   lightA = COL_GREEN;
      ST_A_WARN: lightA = COL_YELLOW;
      ST_B_GO:   lightB = COL_GREEN;
      ST_B_WARN: lightB = COL_YELLOW;
      default:   lightA = COL_RED;
    endcase
  end
endmodule

// File: rtl/crossing_light_ctrl.sv
module crossing_light_ctrl
  import xlc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sensA,
  input  logic       sensB,
  input  logic       paradeReq,
  input  logic       paradeEnd,
  output logic [1:0] lightA,
  output logic [1:0] lightB,
  output logic       paradeOn
);
  ctrl_strobe_t strobes;

  xlc_mode_ctrl i_mode (
    .clk       (clk),
    .rst       (rst),
    .paradeReq (paradeReq),
    .paradeEnd (paradeEnd),
    .strobes   (strobes)
  );

  xlc_light_path i_lights (
    .clk     (clk),
    .rst     (rst),
    .sensA   (sensA),
    .sensB   (sensB),
    .strobes (strobes),
    .lightA  (lightA),
    .lightB  (lightB)
  );

  assign paradeOn = strobes.holdB;
endmodule

// File: rtl/xlc_checker.sv
module xlc_checker (
  input logic       clk,
  input logic       rst,
  input logic       sensA,
  input logic       sensB,
  input logic       paradeReq,
  input logic       paradeEnd,
  input logic [1:0] lightA,
  input logic [1:0] lightB,
  input logic       paradeOn
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (lightA == 2'b00 && lightB == 2'b10 && !paradeOn));

  // R2
  one_red_chk: assert property (@(posedge clk) disable iff (rst)
    (lightA == 2'b10) != (lightB == 2'b10));

  // R3
  a_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (lightA == 2'b00 && sensA) |=> (lightA == 2'b00));

  // R4
  a_warn_adv_chk: assert property (@(posedge clk) disable iff (rst)
    (lightA == 2'b01) |=> (lightB == 2'b00));

  // R4
  b_warn_adv_chk: assert property (@(posedge clk) disable iff (rst)
    (lightB == 2'b01) |=> (lightA == 2'b00));

  // R5
  b_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (lightB == 2'b00 && (paradeOn || sensB)) |=> (lightB == 2'b00));

  // R6
  mode_set_chk: assert property (@(posedge clk) disable iff (rst)
    (paradeReq && !paradeEnd) |=> paradeOn);

  // R6
  mode_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (paradeEnd && !paradeReq) |=> !paradeOn);

  // R7
  mode_tie_chk: assert property (@(posedge clk) disable iff (rst)
    (paradeEnd && paradeReq) |=> $stable(paradeOn));
endmodule

bind crossing_light_ctrl xlc_checker i_chk (.*);

// File: tb/test_crossing_light_ctrl.sv
module test_crossing_light_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sensA = 1'b0, sensB = 1'b0, paradeReq = 1'b0, paradeEnd = 1'b0;
  logic [1:0] lightA, lightB;
  logic paradeOn;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  logic [4:0] expQ[$];
  string      tagQ[$];

  int  mState = 0;
  logic mMode = 1'b0;

  always #4 clk = ~clk;

  crossing_light_ctrl i_crossing_light_ctrl (
    .clk(clk), .rst(rst), .sensA(sensA), .sensB(sensB),
    .paradeReq(paradeReq), .paradeEnd(paradeEnd),
    .lightA(lightA), .lightB(lightB), .paradeOn(paradeOn)
  );

  function automatic logic [3:0] colors(int s);
    case (s)
      0: return 4'b00_10;
      1: return 4'b01_10;
      2: return 4'b10_00;
      default: return 4'b10_01;
    endcase
  endfunction

  // driver: apply inputs for one edge and push the expected result
  task automatic drive(input logic r, input logic a, input logic b,
                       input logic p, input logic e, input string tag);
    int nState;
    logic nMode;
    @(negedge clk);
    rst = r; sensA = a; sensB = b; paradeReq = p; paradeEnd = e;
    if (r) begin
      nState = 0; nMode = 1'b0;
    end else begin
      case (mState)
        0: nState = a ? 0 : 1;
        1: nState = 2;
        2: nState = (mMode || b) ? 2 : 3;
        default: nState = 0;
      endcase
      nMode = (p && !e) ? 1'b1 : (e && !p) ? 1'b0 : mMode;
    end
    mState = nState;
    mMode  = nMode;
    expQ.push_back({colors(nState), nMode});
    tagQ.push_back(tag);
  endtask

  // monitor: compare after every edge
  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      logic [4:0] exp;
      string tag;
      exp = expQ.pop_front();
      tag = tagQ.pop_front();
      compared++;
      if ({lightA, lightB, paradeOn} !== exp) begin
        mismatched++;
        $display("FAIL %s: got lightA=%b lightB=%b paradeOn=%b, expected lightA=%b lightB=%b paradeOn=%b",
                 tag, lightA, lightB, paradeOn, exp[4:3], exp[2:1], exp[0]);
      end
    end
  end

  initial begin
    #(8 * 5000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: got no end of run, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    drive(1, 1, 1, 1, 0, "R1 reset");
    drive(1, 0, 0, 0, 0, "R1 reset");
    // R3 and R2: A green held by traffic on A
    for (int i = 0; i < 3; i++) drive(0, 1, 0, 0, 0, "R3 hold A");
    drive(0, 0, 1, 0, 0, "R3 leave A / R2 yellow");
    drive(0, 1, 1, 0, 0, "R4 A-yellow to B-green");
    drive(0, 1, 1, 0, 0, "R5 hold on sensB");
    drive(0, 0, 1, 0, 0, "R5 hold on sensB");
    drive(0, 0, 0, 0, 0, "R5 leave B / R2 B yellow");
    drive(0, 0, 1, 0, 0, "R4 B-yellow to A ignoring sensB");
    // R6: enter parade while moving to A-yellow
    drive(0, 0, 0, 1, 0, "R6 set parade");
    drive(0, 0, 0, 0, 0, "R4 to B-green");
    for (int i = 0; i < 3; i++) drive(0, 0, 0, 0, 0, "R5 parade hold");
    drive(0, 0, 0, 1, 1, "R7 tie holds mode");
    drive(0, 0, 0, 0, 0, "R7 still held");
    drive(0, 0, 0, 0, 1, "R8 end pulse, still B-green");
    drive(0, 0, 0, 0, 0, "R8 leave one edge later");
    drive(0, 1, 0, 0, 0, "R4 back to A");
    // R8: request in the cycle B-green is left
    drive(0, 0, 0, 0, 0, "R3 leave A");
    drive(0, 0, 0, 0, 0, "R4 to B-green");
    drive(0, 0, 0, 1, 0, "R8 request while leaving B");
    drive(0, 0, 0, 0, 0, "R4 B-yellow to A in parade");
    drive(0, 0, 0, 0, 0, "R3 leave A in parade");
    drive(0, 0, 0, 0, 0, "R4 to B-green");
    drive(0, 0, 0, 0, 0, "R5 parade hold");
    // R9 reset during hold
    drive(1, 0, 0, 0, 0, "R9 reset mid-parade");
    drive(0, 1, 0, 0, 0, "R9 after reset");
    // R7 tie with mode off
    drive(0, 1, 0, 1, 1, "R7 tie keeps mode off");
    drive(0, 1, 0, 0, 1, "R6 end alone keeps off");
    drive(0, 1, 0, 0, 0, "R6 idle holds");
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule